// File: doc/BRIEF.md
# Exception Entry and Register Bank Controller

This block holds the control state of a 32-bit processor core: the program counter, the status register, the vector base, the floating-point control word, the saved-context registers and the event-code registers. When a reset request, a synchronous exception (general, trap or TLB miss) or an interrupt arrives, it saves the context and steers the program counter to the matching vector, all in one clock cycle.

Registers r0 to r7 of the general file come in two physical banks. The active bank is chosen by the AND of the status register's privileged-mode bit and bank bit. Any change of that AND, whether from a direct write or from event entry, exchanges the active eight with the shadow eight. Registers r8 to r15 are not banked. The floating-point file holds two banks of sixteen words, and the bank bit of the control word chooses between them.

Instruction decode, address translation and interrupt arbitration live outside the block. They drive the request pins, the codes and the delay-slot flag.

Top module: `ctx_excp_ctrl`

## Requirements
- R1: Synchronous reset sets the program counter to 0xA0000000, the vector base to 0, the status register to 0x700000F0, the floating-point control word to 0x00040001, and the saved-context and event-code registers to 0.
- R2: On an exception or an interrupt, the saved status register takes the status register's value and the saved stack register takes r15. The saved program counter takes the program counter, adjusted as R8 describes.
- R3: On any event, the status register gets bits 30 (mode), 29 (bank) and 28 (block) set. For exceptions and interrupts, all other bits keep their value from before the event.
- R4: An exception with kind 2'b00 or 2'b11 jumps to vector base + 0x100 and records its code in the exception-code register.
- R5: An exception with kind 2'b01 is a trap. It writes the 8-bit immediate shifted left by 2 into the trap-code register, records code 0x160 and jumps to vector base + 0x100.
- R6: An exception with kind 2'b10 is a TLB miss. It jumps to vector base + 0x400 and records its code.
- R7: An interrupt jumps to vector base + 0x600 and records its code in the interrupt-code register. The exception-code register keeps its value.
- R8: An exception taken with the delay-slot flag high saves the program counter minus 2. An interrupt always saves the unmodified program counter.
- R9: A status-register write that changes (bit 30 AND bit 29) exchanges r0..r7 with their shadow copies. A write that leaves that AND unchanged does not exchange them. r8..r15 are never affected.
- R10: A reset request sets the vector base to 0, the program counter to 0xA0000000, the status register to 0x700000F0 (mode, bank, block and the full interrupt mask set, FPU-disable bit 15 clear) and the floating-point control word to 0x00040001. It records the request's code and leaves the saved-context registers unchanged.
- R11: A write to the floating-point control word that toggles bit 21 switches which of the two 16-word floating-point banks is visible. A write that keeps bit 21 does not switch banks.
- R12: When requests arrive together, reset wins over an exception and an exception wins over an interrupt. The losing interrupt leaves the interrupt-code register unchanged. Direct writes to the program counter, status register, vector base or control word are ignored in any cycle that takes an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Reset-exception request |
| reset_code | input | 12 | Code recorded on a reset request |
| exc_req | input | 1 | Exception request |
| exc_kind | input | 2 | 00 general, 01 trap, 10 TLB miss, 11 general |
| exc_code | input | 12 | Code recorded on a non-trap exception |
| trap_imm | input | 8 | Trap immediate |
| int_req | input | 1 | Interrupt request |
| int_code | input | 12 | Interrupt code |
| in_slot | input | 1 | Faulting instruction sits in a delay slot |
| pc_we | input | 1 | Direct program-counter load |
| pc_wdata | input | 32 | Value for the program counter |
| sr_we | input | 1 | Direct status-register write |
| sr_wdata | input | 32 | Value for the status register |
| vbase_we | input | 1 | Vector-base write |
| vbase_wdata | input | 32 | Value for the vector base |
| fpctl_we | input | 1 | Floating-point control-word write |
| fpctl_wdata | input | 32 | Value for the control word |
| gr_we | input | 1 | General register write |
| gr_widx | input | 4 | General register write index |
| gr_wdata | input | 32 | General register write data |
| gr_ridx | input | 4 | General register read index |
| fr_we | input | 1 | Floating-point register write |
| fr_widx | input | 4 | Floating-point register write index |
| fr_wdata | input | 32 | Floating-point register write data |
| fr_ridx | input | 4 | Floating-point register read index |
| pc_o | output | 32 | Program counter |
| sr_o | output | 32 | Status register |
| vbase_o | output | 32 | Vector base |
| fpctl_o | output | 32 | Floating-point control word |
| save_pc_o | output | 32 | Saved program counter |
| save_sr_o | output | 32 | Saved status register |
| save_sp_o | output | 32 | Saved r15 |
| exc_evt_o | output | 12 | Exception-code register |
| int_evt_o | output | 12 | Interrupt-code register |
| trap_code_o | output | 32 | Trap-code register |
| gr_rdata_o | output | 32 | General register read data, one cycle after the index |
| fr_rdata_o | output | 32 | Floating-point register read data, one cycle after the index |

## Verification
The bench sweeps every exception kind and interrupts, both delay-slot states and several vector bases. One of the bases wraps past 2^32. A design that applied the slot correction to interrupts, used the wrong offset for a kind, or let an interrupt overwrite the exception code would show a wrong saved or new program counter. The bank checks write different patterns into each bank. They then flip the mode and bank bits one at a time and together, so a design that swapped on either bit alone, or that also swapped r8..r15, returns the wrong word. Simultaneous requests, and direct writes made in an event cycle, expose a wrong priority order or a write that leaks through.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int XLEN   = 32;
  localparam int CODE_W = 12;

  // status-register bit positions the block acts on
  localparam int SR_MD = 30;
  localparam int SR_RB = 29;
  localparam int SR_BL = 28;

  localparam logic [XLEN-1:0] SR_ENTRY_SET = 32'h7000_0000;
  localparam logic [XLEN-1:0] SR_IMASK     = 32'h0000_00F0;
  localparam logic [XLEN-1:0] SR_FPU_OFF   = 32'h0000_8000;

  // floating-point control word bank bit
  localparam int FP_BANK_BIT = 21;

  typedef enum logic [1:0] {
    KIND_GENERAL = 2'b00,
    KIND_TRAP    = 2'b01,
    KIND_TLBMISS = 2'b10,
    KIND_ALT     = 2'b11
  } exc_kind_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_RESET = 2'b01,
    EV_EXC   = 2'b10,
    EV_INT   = 2'b11
  } ev_sel_e;

endpackage

// File: rtl/ctx_event_unit.sv
module ctx_event_unit
  import ctx_pkg::*;
#(
  parameter logic [XLEN-1:0]   RESET_PC  = 32'hA000_0000,
  parameter logic [XLEN-1:0]   RESET_SR  = 32'h7000_00F0,
  parameter logic [XLEN-1:0]   GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0]   TLB_OFS   = 32'h0000_0400,
  parameter logic [XLEN-1:0]   INT_OFS   = 32'h0000_0600,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h160
) (
  input  logic              reset_req,
  input  logic [CODE_W-1:0] reset_code,
  input  logic              exc_req,
  input  exc_kind_e         exc_kind,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              int_req,
  input  logic [CODE_W-1:0] int_code,
  input  logic              in_slot,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_vbase,
  output ev_sel_e           sel,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   nxt_sr,
  output logic [XLEN-1:0]   ret_pc,
  output logic [CODE_W-1:0] nxt_code,
  output logic              take_trap
);

  // status word forced by a reset request
  localparam logic [XLEN-1:0] RST_REQ_SR =
    (RESET_SR | SR_ENTRY_SET | SR_IMASK) & ~SR_FPU_OFF;

  logic [XLEN-1:0] exc_ofs;

  // fixed priority: reset, then exception, then interrupt
  always_comb begin
    if (reset_req)    sel = EV_RESET;
    else if (exc_req) sel = EV_EXC;
    else if (int_req) sel = EV_INT;
    else              sel = EV_NONE;
  end

  assign exc_ofs   = (exc_kind == KIND_TLBMISS) ? TLB_OFS : GEN_OFS;
  assign take_trap = (sel == EV_EXC) && (exc_kind == KIND_TRAP);

  always_comb begin
    nxt_pc   = cur_pc;
    nxt_sr   = cur_sr | SR_ENTRY_SET;
    ret_pc   = cur_pc;
    nxt_code = '0;
    unique case (sel)
      EV_RESET: begin
        nxt_pc   = RESET_PC;
        nxt_sr   = RST_REQ_SR;
        nxt_code = reset_code;
      end
      EV_EXC: begin
        nxt_pc   = cur_vbase + exc_ofs;
        ret_pc   = in_slot ? (cur_pc - XLEN'(2)) : cur_pc;
        nxt_code = (exc_kind == KIND_TRAP) ? TRAP_CODE : exc_code;
      end
      EV_INT: begin
        nxt_pc   = cur_vbase + INT_OFS;
        nxt_code = int_code;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctx_gpr_file.sv
// General register file: the lower NBANK indices are banked, the upper
// NBANK indices are common to both banks.
module ctx_gpr_file #(
  parameter int NBANK = 8,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          bank_sel,
  input  logic                          we,
  input  logic [$clog2(2*NBANK)-1:0]    widx,
  input  logic [DW-1:0]                 wdata,
  input  logic [$clog2(2*NBANK)-1:0]    ridx,
  output logic [DW-1:0]                 rdata,
  output logic [DW-1:0]                 top_reg
);

  localparam int IW = $clog2(2*NBANK);
  localparam int BW = $clog2(NBANK);

  logic [DW-1:0] banked [2*NBANK];
  logic [DW-1:0] common [NBANK];

  always_ff @(posedge clk) begin
    if (we && !widx[IW-1])
      banked[{bank_sel, widx[BW-1:0]}] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && widx[IW-1])
      common[widx[BW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (ridx[IW-1]) rdata <= common[ridx[BW-1:0]];
    else            rdata <= banked[{bank_sel, ridx[BW-1:0]}];
  end

  assign top_reg = common[NBANK-1];

endmodule

// File: rtl/ctx_fpr_file.sv
// Floating-point register file: two full banks, one visible at a time.
module ctx_fpr_file #(
  parameter int NFR = 16,
  parameter int DW  = 32
) (
  input  logic                    clk,
  input  logic                    bank_sel,
  input  logic                    we,
  input  logic [$clog2(NFR)-1:0]  widx,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NFR)-1:0]  ridx,
  output logic [DW-1:0]           rdata
);

  logic [DW-1:0] mem [2*NFR];

  always_ff @(posedge clk) begin
    if (we) mem[{bank_sel, widx}] <= wdata;
    rdata <= mem[{bank_sel, ridx}];
  end

endmodule

// File: rtl/ctx_excp_ctrl.sv
module ctx_excp_ctrl
  import ctx_pkg::*;
#(
  parameter logic [31:0] RESET_PC    = 32'hA000_0000,
  parameter logic [31:0] RESET_SR    = 32'h7000_00F0,
  parameter logic [31:0] RESET_FPCTL = 32'h0004_0001,
  parameter logic [31:0] GEN_OFS     = 32'h0000_0100,
  parameter logic [31:0] TLB_OFS     = 32'h0000_0400,
  parameter logic [31:0] INT_OFS     = 32'h0000_0600,
  parameter logic [11:0] TRAP_CODE   = 12'h160,
  parameter int          NBANK       = 8,
  parameter int          NFR         = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reset_req,
  input  logic [11:0] reset_code,
  input  logic        exc_req,
  input  logic [1:0]  exc_kind,
  input  logic [11:0] exc_code,
  input  logic [7:0]  trap_imm,
  input  logic        int_req,
  input  logic [11:0] int_code,
  input  logic        in_slot,
  input  logic        pc_we,
  input  logic [31:0] pc_wdata,
  input  logic        sr_we,
  input  logic [31:0] sr_wdata,
  input  logic        vbase_we,
  input  logic [31:0] vbase_wdata,
  input  logic        fpctl_we,
  input  logic [31:0] fpctl_wdata,
  input  logic        gr_we,
  input  logic [3:0]  gr_widx,
  input  logic [31:0] gr_wdata,
  input  logic [3:0]  gr_ridx,
  input  logic        fr_we,
  input  logic [3:0]  fr_widx,
  input  logic [31:0] fr_wdata,
  input  logic [3:0]  fr_ridx,
  output logic [31:0] pc_o,
  output logic [31:0] sr_o,
  output logic [31:0] vbase_o,
  output logic [31:0] fpctl_o,
  output logic [31:0] save_pc_o,
  output logic [31:0] save_sr_o,
  output logic [31:0] save_sp_o,
  output logic [11:0] exc_evt_o,
  output logic [11:0] int_evt_o,
  output logic [31:0] trap_code_o,
  output logic [31:0] gr_rdata_o,
  output logic [31:0] fr_rdata_o
);

  ev_sel_e           ev_sel;
  logic [XLEN-1:0]   ev_pc;
  logic [XLEN-1:0]   ev_sr;
  logic [XLEN-1:0]   ev_ret;
  logic [CODE_W-1:0] ev_code;
  logic              ev_trap;
  logic [XLEN-1:0]   r15_val;
  logic              gr_bank;
  logic              fr_bank;

  // the active bank follows mode AND bank; any change of it is the exchange
  assign gr_bank = sr_o[SR_MD] & sr_o[SR_RB];
  assign fr_bank = fpctl_o[FP_BANK_BIT];

  ctx_event_unit #(
    .RESET_PC  (RESET_PC),
    .RESET_SR  (RESET_SR),
    .GEN_OFS   (GEN_OFS),
    .TLB_OFS   (TLB_OFS),
    .INT_OFS   (INT_OFS),
    .TRAP_CODE (TRAP_CODE)
  ) u_event (
    .reset_req (reset_req),
    .reset_code(reset_code),
    .exc_req   (exc_req),
    .exc_kind  (exc_kind_e'(exc_kind)),
    .exc_code  (exc_code),
    .int_req   (int_req),
    .int_code  (int_code),
    .in_slot   (in_slot),
    .cur_pc    (pc_o),
    .cur_sr    (sr_o),
    .cur_vbase (vbase_o),
    .sel       (ev_sel),
    .nxt_pc    (ev_pc),
    .nxt_sr    (ev_sr),
    .ret_pc    (ev_ret),
    .nxt_code  (ev_code),
    .take_trap (ev_trap)
  );

  ctx_gpr_file #(.NBANK(NBANK), .DW(XLEN)) u_gpr (
    .clk     (clk),
    .bank_sel(gr_bank),
    .we      (gr_we),
    .widx    (gr_widx),
    .wdata   (gr_wdata),
    .ridx    (gr_ridx),
    .rdata   (gr_rdata_o),
    .top_reg (r15_val)
  );

  ctx_fpr_file #(.NFR(NFR), .DW(XLEN)) u_fpr (
    .clk     (clk),
    .bank_sel(fr_bank),
    .we      (fr_we),
    .widx    (fr_widx),
    .wdata   (fr_wdata),
    .ridx    (fr_ridx),
    .rdata   (fr_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o        <= RESET_PC;
      sr_o        <= RESET_SR;
      vbase_o     <= '0;
      fpctl_o     <= RESET_FPCTL;
      save_pc_o   <= '0;
      save_sr_o   <= '0;
      save_sp_o   <= '0;
      exc_evt_o   <= '0;
      int_evt_o   <= '0;
      trap_code_o <= '0;
    end else begin
      unique case (ev_sel)
        EV_RESET: begin
          pc_o      <= ev_pc;
          sr_o      <= ev_sr;
          vbase_o   <= '0;
          fpctl_o   <= RESET_FPCTL;
          exc_evt_o <= ev_code;
        end
        EV_EXC: begin
          pc_o      <= ev_pc;
          sr_o      <= ev_sr;
          save_pc_o <= ev_ret;
          save_sr_o <= sr_o;
          save_sp_o <= r15_val;
          exc_evt_o <= ev_code;
          if (ev_trap) trap_code_o <= {22'd0, trap_imm, 2'b00};
        end
        EV_INT: begin
          pc_o      <= ev_pc;
          sr_o      <= ev_sr;
          save_pc_o <= ev_ret;
          save_sr_o <= sr_o;
          save_sp_o <= r15_val;
          int_evt_o <= ev_code;
        end
        default: begin
          if (pc_we)    pc_o    <= pc_wdata;
          if (sr_we)    sr_o    <= sr_wdata;
          if (vbase_we) vbase_o <= vbase_wdata;
          if (fpctl_we) fpctl_o <= fpctl_wdata;
        end
      endcase
    end
  end

  // R2
  ssr_save_chk: assert property (@(posedge clk) disable iff (rst)
    (!reset_req && (exc_req || int_req)) |=> save_sr_o == $past(sr_o));

  // R3
  entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_req || exc_req || int_req) |=> (sr_o[SR_MD] && sr_o[SR_BL] && sr_o[SR_RB]));

  // R7
  int_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (int_req && !exc_req && !reset_req) |=> pc_o == $past(vbase_o) + INT_OFS);

  // R8
  slot_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !reset_req && in_slot) |=> save_pc_o == $past(pc_o) - 32'd2);

  // R10
  rst_req_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> (vbase_o == 32'd0 && pc_o == RESET_PC && fpctl_o == RESET_FPCTL));

  // R12
  int_lose_chk: assert property (@(posedge clk) disable iff (rst)
    (int_req && (exc_req || reset_req)) |=> $stable(int_evt_o));

endmodule

// File: tb/ctx_excp_ctrl_tb.sv
`timescale 1ns/1ps
module ctx_excp_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reset_req = 1'b0;
  logic [11:0] reset_code = '0;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_kind = '0;
  logic [11:0] exc_code = '0;
  logic [7:0]  trap_imm = '0;
  logic        int_req = 1'b0;
  logic [11:0] int_code = '0;
  logic        in_slot = 1'b0;
  logic        pc_we = 1'b0;
  logic [31:0] pc_wdata = '0;
  logic        sr_we = 1'b0;
  logic [31:0] sr_wdata = '0;
  logic        vbase_we = 1'b0;
  logic [31:0] vbase_wdata = '0;
  logic        fpctl_we = 1'b0;
  logic [31:0] fpctl_wdata = '0;
  logic        gr_we = 1'b0;
  logic [3:0]  gr_widx = '0;
  logic [31:0] gr_wdata = '0;
  logic [3:0]  gr_ridx = '0;
  logic        fr_we = 1'b0;
  logic [3:0]  fr_widx = '0;
  logic [31:0] fr_wdata = '0;
  logic [3:0]  fr_ridx = '0;
  logic [31:0] pc_o, sr_o, vbase_o, fpctl_o, save_pc_o, save_sr_o, save_sp_o;
  logic [11:0] exc_evt_o, int_evt_o;
  logic [31:0] trap_code_o, gr_rdata_o, fr_rdata_o;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] e_pc, e_sr, e_spc, e_ssr, e_sgr, e_tra, vb, pv, sv;
  logic [11:0] e_exp, e_int, cd;
  logic [7:0]  im;

  always #4 clk = ~clk;

  ctx_excp_ctrl u_dut (
    .clk(clk), .rst(rst),
    .reset_req(reset_req), .reset_code(reset_code),
    .exc_req(exc_req), .exc_kind(exc_kind), .exc_code(exc_code), .trap_imm(trap_imm),
    .int_req(int_req), .int_code(int_code), .in_slot(in_slot),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
    .fpctl_we(fpctl_we), .fpctl_wdata(fpctl_wdata),
    .gr_we(gr_we), .gr_widx(gr_widx), .gr_wdata(gr_wdata), .gr_ridx(gr_ridx),
    .fr_we(fr_we), .fr_widx(fr_widx), .fr_wdata(fr_wdata), .fr_ridx(fr_ridx),
    .pc_o(pc_o), .sr_o(sr_o), .vbase_o(vbase_o), .fpctl_o(fpctl_o),
    .save_pc_o(save_pc_o), .save_sr_o(save_sr_o), .save_sp_o(save_sp_o),
    .exc_evt_o(exc_evt_o), .int_evt_o(int_evt_o), .trap_code_o(trap_code_o),
    .gr_rdata_o(gr_rdata_o), .fr_rdata_o(fr_rdata_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    reset_req = 0; exc_req = 0; int_req = 0; in_slot = 0;
    pc_we = 0; sr_we = 0; vbase_we = 0; fpctl_we = 0; gr_we = 0; fr_we = 0;
  endtask

  task automatic wr_gr(input logic [3:0] i, input logic [31:0] d);
    gr_we = 1; gr_widx = i; gr_wdata = d; step(); gr_we = 0;
  endtask

  task automatic wr_fr(input logic [3:0] i, input logic [31:0] d);
    fr_we = 1; fr_widx = i; fr_wdata = d; step(); fr_we = 0;
  endtask

  task automatic wr_sr(input logic [31:0] d);
    sr_we = 1; sr_wdata = d; step(); sr_we = 0;
  endtask

  task automatic wr_fp(input logic [31:0] d);
    fpctl_we = 1; fpctl_wdata = d; step(); fpctl_we = 0;
  endtask

  task automatic rd_gr(input string req, input logic [3:0] i, input logic [31:0] exp);
    gr_ridx = i; step(); chk(req, $sformatf("r%0d", i), gr_rdata_o, exp);
  endtask

  task automatic rd_fr(input string req, input logic [3:0] i, input logic [31:0] exp);
    fr_ridx = i; step(); chk(req, $sformatf("fr%0d", i), fr_rdata_o, exp);
  endtask

  function automatic logic [31:0] vtab(input int v);
    case (v)
      0: return 32'h8C00_0000;
      1: return 32'h0000_1000;
      default: return 32'hFFFF_FF00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc_o, 32'hA000_0000);
    chk("R1", "sr", sr_o, 32'h7000_00F0);
    chk("R1", "vbase", vbase_o, 32'h0);
    chk("R1", "fpctl", fpctl_o, 32'h0004_0001);
    chk("R1", "exc_evt", {20'd0, exc_evt_o}, 32'h0);
    chk("R1", "save_pc", save_pc_o, 32'h0);
    e_exp = '0; e_int = '0; e_tra = '0;

    // R9 bank exchange: active bank is 1 after reset
    for (int i = 0; i < 16; i++) wr_gr(4'(i), 32'h1000_0000 + i);
    wr_sr(32'h0000_0000);
    for (int i = 0; i < 8; i++) wr_gr(4'(i), 32'h2000_0000 + i);
    rd_gr("R9", 4'd0, 32'h2000_0000);
    rd_gr("R9", 4'd12, 32'h1000_000C);
    wr_sr(32'h4000_0000);                  // mode only: no exchange
    rd_gr("R9", 4'd1, 32'h2000_0001);
    wr_sr(32'h6000_0000);                  // both: exchange
    for (int i = 0; i < 16; i++) rd_gr("R9", 4'(i), 32'h1000_0000 + i);
    wr_sr(32'h2000_0000);                  // bank only: exchange back
    rd_gr("R9", 4'd3, 32'h2000_0003);
    rd_gr("R9", 4'd15, 32'h1000_000F);

    // R2..R8 event sweep; k==4 means interrupt
    for (int v = 0; v < 3; v++) begin
      for (int k = 0; k < 5; k++) begin
        for (int s = 0; s < 2; s++) begin
          vb = vtab(v);
          pv = 32'h8C01_0000 + 32'(v * 256 + k * 16 + s * 4);
          sv = 32'h0000_0301 | 32'(k << 4) | 32'(s << 9);
          cd = 12'h0E0 + 12'(k * 32 + v);
          im = 8'hC0 + 8'(v * 7 + k);
          pc_we = 1; pc_wdata = pv; sr_we = 1; sr_wdata = sv;
          vbase_we = 1; vbase_wdata = vb;
          step(); quiet();
          in_slot = s[0];
          if (k == 4) begin
            int_req = 1; int_code = cd;
          end else begin
            exc_req = 1; exc_kind = 2'(k); exc_code = cd; trap_imm = im;
          end
          step(); quiet();
          e_pc  = (k == 4) ? vb + 32'h600 : (k == 2) ? vb + 32'h400 : vb + 32'h100;
          e_spc = (k < 4 && s == 1) ? pv - 32'd2 : pv;
          e_sr  = sv | 32'h7000_0000;
          if (k == 4) e_int = cd;
          else if (k == 1) begin e_exp = 12'h160; e_tra = {22'd0, im, 2'b00}; end
          else e_exp = cd;
          chk((k == 4) ? "R7" : (k == 2) ? "R6" : (k == 1) ? "R5" : "R4", "pc", pc_o, e_pc);
          chk("R8", "save_pc", save_pc_o, e_spc);
          chk("R2", "save_sr", save_sr_o, sv);
          chk("R2", "save_sp", save_sp_o, 32'h1000_000F);
          chk("R3", "sr", sr_o, e_sr);
          chk((k == 4) ? "R7" : "R4", "exc_evt", {20'd0, exc_evt_o}, {20'd0, e_exp});
          chk("R7", "int_evt", {20'd0, int_evt_o}, {20'd0, e_int});
          chk("R5", "trap_code", trap_code_o, e_tra);
        end
      end
    end

    // R12 exception beats interrupt; direct writes in that cycle ignored
    pc_we = 1; pc_wdata = 32'h0C00_0040; sr_we = 1; sr_wdata = 32'h0000_0002;
    vbase_we = 1; vbase_wdata = 32'h0C00_0000;
    step(); quiet();
    exc_req = 1; exc_kind = 2'b00; exc_code = 12'h1E0;
    int_req = 1; int_code = 12'h3C0;
    sr_we = 1; sr_wdata = 32'h0000_0000; vbase_we = 1; vbase_wdata = 32'h5555_0000;
    step(); quiet();
    chk("R12", "pc", pc_o, 32'h0C00_0100);
    chk("R12", "exc_evt", {20'd0, exc_evt_o}, 32'h1E0);
    chk("R12", "int_evt", {20'd0, int_evt_o}, {20'd0, e_int});
    chk("R12", "sr", sr_o, 32'h7000_0002);
    chk("R12", "vbase", vbase_o, 32'h0C00_0000);

    // R11 floating-point banks
    for (int i = 0; i < 16; i++) wr_fr(4'(i), 32'h3000_0000 + i);
    wr_fp(32'h0024_0001);
    chk("R11", "fpctl", fpctl_o, 32'h0024_0001);
    for (int i = 0; i < 16; i++) wr_fr(4'(i), 32'h4000_0000 + i);
    wr_fp(32'h0020_0000);                  // bit 21 kept
    rd_fr("R11", 4'd2, 32'h4000_0002);
    wr_fp(32'h0000_0001);                  // bit 21 toggled
    rd_fr("R11", 4'd2, 32'h3000_0002);
    rd_fr("R11", 4'd15, 32'h3000_000F);
    wr_fp(32'h0020_0001);

    // R10 reset request beats everything; FPU-disable cleared
    wr_sr(32'h0000_8003);
    e_spc = save_pc_o; e_ssr = save_sr_o; e_sgr = save_sp_o;
    reset_req = 1; reset_code = 12'h020;
    exc_req = 1; exc_kind = 2'b00; exc_code = 12'h0A0;
    int_req = 1; int_code = 12'h7E0;
    step(); quiet();
    chk("R10", "pc", pc_o, 32'hA000_0000);
    chk("R10", "sr", sr_o, 32'h7000_00F0);
    chk("R10", "vbase", vbase_o, 32'h0);
    chk("R10", "fpctl", fpctl_o, 32'h0004_0001);
    chk("R10", "exc_evt", {20'd0, exc_evt_o}, 32'h020);
    chk("R12", "int_evt", {20'd0, int_evt_o}, {20'd0, e_int});
    chk("R10", "save_pc", save_pc_o, e_spc);
    chk("R10", "save_sr", save_sr_o, e_ssr);
    chk("R10", "save_sp", save_sp_o, e_sgr);
    rd_fr("R11", 4'd5, 32'h3000_0005);     // control word reset flipped bank
    rd_gr("R9", 4'd4, 32'h1000_0004);      // mode and bank set again

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule